// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Scheduler

This block sits in the command path of an SDRAM controller. It accepts one read request at a time. The request names a bank, a column, the number of data beats wanted, an end style (precharge or burst terminate) and an auto-precharge wish. The block issues the READ and then closes the burst. It places the closing PRECHARGE or BURST TERMINATE CL-1 cycles before the clock edge that carries the last wanted beat. Because the read data arrives CL cycles after the command, that placement always falls exactly N cycles after the READ for N wanted beats. A one-cycle strobe marks each wanted beat on the returning data bus. Beats the bus still carries after the truncation point are not marked.

The CAS latency is selected per request (2 or 3). So is the burst mode: a fixed four-beat burst, or a full page with no natural end. A fixed burst that asked for auto precharge is never truncated. A request too short to be truncated in time is flagged, and the burst is handled as the requirements below describe. Each bank has a precharge-wait counter. It holds off a new READ to that bank until the row-precharge time has passed since that bank's precharge, whether the precharge was explicit or automatic.

Top module: `rd_trunc_sched`

## Requirements
- R1: After reset the command bus shows NOP (code 0), the data strobe and the error flag are low, and the block is ready.
- R2: A request taken at a rising edge (req_valid and req_ready both high) drives READ (code 1) in the next cycle, with the request's bank and column.
- R3: For N delivered beats, rd_valid is high in exactly the cycles CL to CL+N-1 after the READ cycle, and low at every other cycle.
- R4: A truncated burst ends with PRECHARGE (code 2) or BURST TERMINATE (code 3), chosen by req_end (0 or 1). This command goes to the READ's bank exactly N cycles after the READ, which is CL-1 cycles before the last wanted beat.
- R5: A fixed burst without auto precharge, asking for 4 or more beats, delivers 4 beats. In precharge mode it issues PRECHARGE 4 cycles after the READ. In terminate mode it issues no closing command.
- R6: A fixed-mode request with auto precharge drives cmd_autopre high with the READ. It never receives PRECHARGE or BURST TERMINATE and delivers all 4 beats. It raises trunc_err if fewer than 4 beats were asked for.
- R7: In full-page mode every burst is closed by PRECHARGE or BURST TERMINATE, and the auto-precharge wish is ignored (cmd_autopre low).
- R8: A request for fewer beats than CL-1 raises trunc_err in the READ cycle. In fixed mode the burst then runs unmodified, as in R5. In full-page mode it closes at cycle CL-1.
- R9: A READ to a bank comes no earlier than TRP_CYC cycles after that bank's PRECHARGE cycle, or after the point 4 cycles past an auto-precharge READ. A waiting request is served in exactly that cycle. Other banks are not held off.
- R10: Every cycle with no READ or closing command drives NOP.
- R11: req_ready stays low from the READ until the last wanted beat has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl3 | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| cfg_fullpage | input | 1 | 1: full-page bursts, 0: fixed 4-beat bursts |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_beats | input | BEAT_W | Wanted beat count |
| req_end | input | 1 | 0: close with PRECHARGE, 1: close with BURST TERMINATE |
| req_autopre | input | 1 | Ask for auto precharge (fixed mode only) |
| cmd_code | output | 2 | 0 NOP, 1 READ, 2 PRECHARGE, 3 BURST TERMINATE |
| cmd_bank | output | BA_W | Bank of the command |
| cmd_col | output | COL_W | Column of the READ |
| cmd_autopre | output | 1 | Auto-precharge bit of the READ |
| rd_valid | output | 1 | Marks a wanted read beat on the data bus |
| trunc_err | output | 1 | Truncation refused, pulsed with the READ |

## Verification
A wrong internal cycle count shows up on the command bus within one burst. The closing command appears a cycle early or late, or at the wrong bank. The strobe window shifts or widens within CL+N cycles of the READ. A stale precharge-wait counter shows up one request later, when the next READ to that bank is placed earlier or later than the exact cycle the bench predicts. A mistake in the plan decoder shows up in the READ cycle as a wrong error pulse or a wrong auto-precharge bit.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_READ = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_BST  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_PRE  = 2'd1,
    END_BST  = 2'd2,
    END_AUTO = 2'd3
  } endact_e;
endpackage

// File: rtl/rts_plan.sv
// Decodes a request into the closing cycle, the delivered beat count and the closing action.
module rts_plan
  import rts_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int BL     = 4,
  parameter int T_W    = BEAT_W + 2
) (
  input  logic [BEAT_W-1:0] beats,
  input  logic              cl3,
  input  logic              fullpage,
  input  logic              autopre,
  input  logic              end_bst,
  output logic [T_W-1:0]    end_cyc,
  output logic [T_W-1:0]    n_beats,
  output endact_e           act,
  output logic              err,
  output logic              ap_eff
);
  logic [T_W-1:0] cl_m1, bx, blx, n;
  logic           short_req;

  always_comb begin
    cl_m1     = cl3 ? T_W'(2) : T_W'(1);
    bx        = T_W'(beats);
    blx       = T_W'(BL);
    short_req = (bx < cl_m1);
    n         = blx;
    ap_eff    = 1'b0;
    err       = 1'b0;
    act       = END_NONE;
    if (fullpage) begin
      n   = short_req ? cl_m1 : bx;
      err = short_req;
      act = end_bst ? END_BST : END_PRE;
    end else if (autopre) begin
      n      = blx;
      ap_eff = 1'b1;
      err    = (bx < blx);
      act    = END_AUTO;
    end else begin
      n   = (short_req || (bx >= blx)) ? blx : bx;
      err = short_req;
      if (n == blx) act = end_bst ? END_NONE : END_PRE;
      else          act = end_bst ? END_BST : END_PRE;
    end
    end_cyc = n;
    n_beats = n;
  end
endmodule

// File: rtl/rts_trp_bank.sv
// Per-bank precharge wait counters.
module rts_trp_bank #(
  parameter int NB      = 4,
  parameter int TRP_CYC = 3,
  parameter int BA_W    = $clog2(NB),
  parameter int CNT_W   = $clog2(TRP_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BA_W-1:0] load_bank,
  input  logic [BA_W-1:0] query_bank,
  output logic            query_ok
);
  logic [CNT_W-1:0] cnt_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_d;
    always_comb begin
      cnt_d = cnt_q[b];
      if (load && (load_bank == BA_W'(b))) cnt_d = CNT_W'(TRP_CYC);
      else if (cnt_q[b] != '0)             cnt_d = cnt_q[b] - 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[b] <= '0;
      else        cnt_q[b] <= cnt_d;
    end
  end

  // A READ in the next cycle is legal once the remaining wait is at most one.
  assign query_ok = (cnt_q[query_bank] <= CNT_W'(1));
endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched
  import rts_pkg::*;
#(
  parameter int NB      = 4,
  parameter int COL_W   = 9,
  parameter int BEAT_W  = 8,
  parameter int BL      = 4,
  parameter int TRP_CYC = 3,
  localparam int BA_W   = $clog2(NB),
  localparam int T_W    = BEAT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic              cfg_fullpage,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_end,
  input  logic              req_autopre,
  output logic [1:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_autopre,
  output logic              rd_valid,
  output logic              trunc_err
);
  logic [T_W-1:0] p_end, p_nv;
  endact_e        p_act;
  logic           p_err, p_ap;

  rts_plan #(.BEAT_W(BEAT_W), .BL(BL), .T_W(T_W)) u_plan (
    .beats(req_beats), .cl3(cfg_cl3), .fullpage(cfg_fullpage),
    .autopre(req_autopre), .end_bst(req_end),
    .end_cyc(p_end), .n_beats(p_nv), .act(p_act), .err(p_err), .ap_eff(p_ap)
  );

  logic            busy_q, busy_d;
  logic [T_W-1:0]  t_q, t_d, endc_q, nv_q;
  endact_e         act_q;
  logic            cl3_q;
  logic [BA_W-1:0] bank_q;
  logic [COL_W-1:0] col_q;
  logic            ap_q;
  cmd_e            cmd_q, cmd_d;
  logic            vld_q, vld_d, err_q, err_d;
  logic            bank_ok, accept, trp_load;
  logic [T_W-1:0]  tn, cl_x, last_t;

  rts_trp_bank #(.NB(NB), .TRP_CYC(TRP_CYC), .BA_W(BA_W)) u_trp (
    .clk(clk), .rst_n(rst_n), .load(trp_load), .load_bank(bank_q),
    .query_bank(req_bank), .query_ok(bank_ok)
  );

  assign req_ready = !busy_q && bank_ok;
  assign accept    = req_valid && req_ready;
  assign tn        = t_q + 1'b1;
  assign cl_x      = cl3_q ? T_W'(3) : T_W'(2);
  assign last_t    = cl_x + nv_q - 1'b1;

  // Next-state logic
  always_comb begin
    busy_d   = busy_q;
    t_d      = t_q;
    cmd_d    = CMD_NOP;
    vld_d    = 1'b0;
    err_d    = 1'b0;
    trp_load = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      t_d    = '0;
      cmd_d  = CMD_READ;
      err_d  = p_err;
    end else if (busy_q) begin
      t_d = tn;
      if (tn == endc_q) begin
        case (act_q)
          END_PRE:  begin cmd_d = CMD_PRE; trp_load = 1'b1; end
          END_BST:  cmd_d = CMD_BST;
          END_AUTO: trp_load = 1'b1;
          default:  cmd_d = CMD_NOP;
        endcase
      end
      vld_d = (tn >= cl_x) && (tn < cl_x + nv_q);
      if (t_q == last_t) busy_d = 1'b0;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      cmd_q  <= CMD_NOP;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      t_q    <= t_d;
      cmd_q  <= cmd_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  // Request fields, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      endc_q <= '0;
      nv_q   <= '0;
      act_q  <= END_NONE;
      cl3_q  <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
    end else if (accept) begin
      endc_q <= p_end;
      nv_q   <= p_nv;
      act_q  <= p_act;
      cl3_q  <= cfg_cl3;
      bank_q <= req_bank;
      col_q  <= req_col;
      ap_q   <= p_ap;
    end
  end

  assign cmd_code    = cmd_q;
  assign cmd_bank    = bank_q;
  assign cmd_col     = col_q;
  assign cmd_autopre = ap_q;
  assign rd_valid    = vld_q;
  assign trunc_err   = err_q;
endmodule

// File: rtl/rts_sched_chk.sv
module rts_sched_chk #(
  parameter int NB      = 4,
  parameter int COL_W   = 9,
  parameter int TRP_CYC = 3,
  parameter int BA_W    = $clog2(NB),
  parameter int SW      = $clog2(TRP_CYC + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_fullpage,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      cmd_code,
  input logic [BA_W-1:0] cmd_bank,
  input logic            cmd_autopre,
  input logic            rd_valid
);
  logic [SW-1:0] since_q [NB];
  logic          ap_flag_q;

  for (genvar b = 0; b < NB; b++) begin : g_since
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        since_q[b] <= SW'(TRP_CYC);
      else if (cmd_code == 2'd2 && cmd_bank == BA_W'(b)) since_q[b] <= SW'(1);
      else if (since_q[b] < SW'(TRP_CYC))                since_q[b] <= since_q[b] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ap_flag_q <= 1'b0;
    else if (cmd_code == 2'd1)  ap_flag_q <= cmd_autopre;
  end

  p_read_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_code == 2'd1));

  p_not_ready_at_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd1) |-> !req_ready);

  p_trp_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd1) |-> (since_q[cmd_bank] >= SW'(TRP_CYC)));

  p_strobe_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(cmd_code, 2) == 2'd1 || $past(cmd_code, 3) == 2'd1));

  p_no_cut_with_ap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd2 || cmd_code == 2'd3) |-> !ap_flag_q);

  p_fullpage_no_ap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd1 && cfg_fullpage) |-> !cmd_autopre);
endmodule

bind rd_trunc_sched rts_sched_chk #(.NB(NB), .COL_W(COL_W), .TRP_CYC(TRP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fullpage(cfg_fullpage), .req_valid(req_valid),
  .req_ready(req_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .cmd_autopre(cmd_autopre), .rd_valid(rd_valid)
);

// File: tb/test_rd_trunc_sched.sv
`timescale 1ns/1ps
module test_rd_trunc_sched;
  localparam int NB = 4, COL_W = 9, BEAT_W = 8, BL = 4, TRP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cl3 = 1'b0, cfg_fullpage = 1'b0;
  logic req_valid = 1'b0, req_end = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic req_ready, cmd_autopre, rd_valid, trunc_err;
  logic [1:0] cmd_code, cmd_bank;
  logic [COL_W-1:0] cmd_col;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int lastpre [NB];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rd_trunc_sched #(.NB(NB), .COL_W(COL_W), .BEAT_W(BEAT_W), .BL(BL), .TRP_CYC(TRP)) i_rd_trunc_sched (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_fullpage(cfg_fullpage),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col),
    .req_beats(req_beats), .req_end(req_end), .req_autopre(req_autopre),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .rd_valid(rd_valid), .trunc_err(trunc_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Expected behaviour: 0 none, 1 precharge, 2 terminate, 3 automatic
  function automatic void plan(input int beats, input bit cl3, input bit fp, input bit ap,
                               input bit bst, output int n, output int act, output bit err,
                               output bit ape);
    int clm1 = cl3 ? 2 : 1;
    bit sh = beats < clm1;
    ape = 0;
    if (fp) begin
      n = sh ? clm1 : beats; err = sh; act = bst ? 2 : 1;
    end else if (ap) begin
      n = BL; err = beats < BL; act = 3; ape = 1;
    end else begin
      n = (sh || beats >= BL) ? BL : beats; err = sh;
      if (n == BL) act = bst ? 0 : 1;
      else         act = bst ? 2 : 1;
    end
  endfunction

  task automatic run_req(input int bank, input int col, input int beats, input bit bst,
                         input bit ap);
    int n, act, cl, exp_rd, rd_cyc, got, bad_cmd, bad_vld, ac, av, ec, ev;
    bit err, ape;
    string tg;
    cl = cfg_cl3 ? 3 : 2;
    plan(beats, cfg_cl3, cfg_fullpage, ap, bst, n, act, err, ape);
    tg = cfg_fullpage ? "R7" : (ap ? "R6" : (err ? "R8" : (n == BL ? "R5" : "R4")));
    exp_rd = (cyc + 1 > lastpre[bank] + TRP) ? cyc + 1 : lastpre[bank] + TRP;
    req_bank = 2'(bank); req_col = COL_W'(col); req_beats = BEAT_W'(beats);
    req_end = bst; req_autopre = ap; req_valid = 1'b1;
    got = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd_code == 2'd1) begin got = 1; break; end
    end
    req_valid = 1'b0;
    rd_cyc = cyc;
    check(got == 1, "R2 read issued", got, 1);
    check(rd_cyc == exp_rd, "R9 read cycle", rd_cyc, exp_rd);
    check(cmd_bank == 2'(bank) && cmd_col == COL_W'(col), "R2 bank/col", int'(cmd_col), col);
    check(cmd_autopre == ape, ap ? "R6 autopre" : "R7 autopre", int'(cmd_autopre), int'(ape));
    check(trunc_err == err, "R8 error flag", int'(trunc_err), int'(err));
    check(req_ready == 1'b0, "R11 ready low", int'(req_ready), 0);
    bad_cmd = 0; bad_vld = 0; ac = 0; ec = 0; av = 0; ev = 0;
    for (int t = 1; t <= cl + n + 1; t++) begin
      int xc;
      bit xv;
      @(negedge clk);
      xc = 0;
      if (t == n && act == 1) xc = 2;
      if (t == n && act == 2) xc = 3;
      xv = (t >= cl) && (t < cl + n);
      if (int'(cmd_code) != xc && bad_cmd == 0) begin bad_cmd = t; ac = cmd_code; ec = xc; end
      if (rd_valid != xv && bad_vld == 0) begin bad_vld = t; av = rd_valid; ev = xv; end
      if (t < cl + n && req_ready && bad_cmd == 0) begin bad_cmd = t; ac = 9; ec = 0; end
      if (xc == 2) check(cmd_bank == 2'(bank), "R4 pre bank", int'(cmd_bank), bank);
    end
    check(bad_cmd == 0, {tg, " R10 R11 command trace"}, ac, ec);
    check(bad_vld == 0, {tg, " R3 strobe window"}, av, ev);
    if (act == 1 || act == 3) lastpre[bank] = rd_cyc + n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    int r;
    for (int b = 0; b < NB; b++) lastpre[b] = -100;
    repeat (3) @(negedge clk);
    check(cmd_code == 2'd0 && rd_valid == 0 && trunc_err == 0, "R1 reset outputs", int'(cmd_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // Directed: truncation at each latency, both end styles
    cfg_fullpage = 0; cfg_cl3 = 0; run_req(0, 17, 2, 0, 0);   // R4 precharge, CL2
    cfg_cl3 = 1;                   run_req(1, 33, 3, 1, 0);   // R4 terminate, CL3
    cfg_cl3 = 1;                   run_req(2, 5, 1, 0, 0);    // R8 short at CL3, fixed
    cfg_cl3 = 0;                   run_req(3, 9, 7, 0, 0);    // R5 completion, precharge
    run_req(3, 10, 4, 1, 0);                                  // R5 completion, terminate; R9 wait
    run_req(0, 11, 2, 0, 1);                                  // R6 auto precharge refused cut
    run_req(0, 12, 4, 1, 0);                                  // R9 after auto point
    cfg_fullpage = 1; cfg_cl3 = 1; run_req(2, 300, 12, 1, 1); // R7 terminate, ap ignored
    run_req(2, 301, 0, 0, 0);                                 // R8 full-page short
    cfg_cl3 = 0; run_req(1, 40, 5, 0, 0);                     // R7 precharge
    // R9: same bank held, other bank free
    req_bank = 2'd1; #1;
    check(req_ready == 1'b0, "R9 same bank held", int'(req_ready), 0);
    req_bank = 2'd2; #1;
    check(req_ready == 1'b1, "R9 other bank free", int'(req_ready), 1);
    run_req(1, 41, 3, 1, 0);                                  // R9 exact wait cycle

    // Constrained random
    for (int k = 0; k < 80; k++) begin
      r = $urandom(seed + k);
      cfg_cl3 = r[0]; cfg_fullpage = r[1];
      run_req(int'(r[3:2]), int'(r[12:4]), cfg_fullpage ? int'(r[17:13]) : int'(r[15:13]),
              r[18], r[19]);
      if (r[21:20] == 2'd0) repeat (2) @(negedge clk);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule